// File: doc/BRIEF.md
# DMA Stream Checksum Sniffer

This block observes the data beats that a DMA engine moves and keeps a running 32-bit integrity value over the beats of one selected channel. The DMA engine presents every beat with its data word, its transfer size and the number of the channel that issued it, plus that channel's own sniff-permission flag. The sniffer folds a beat into its accumulator only when it is enabled, the beat is valid, the channel number equals the configured one and the channel's permission flag is set.

One accumulator serves six algorithms chosen by a 4-bit mode: a 32-bit CRC and a 16-bit CRC, each over plain or bit-reversed beat data, an odd-parity bit and a 32-bit sum. An optional input byte swap reorders the beat before it is folded in. Two output options, bit reversal and inversion, are applied only to the value presented on `result`. The running state is never changed by them. Software seeds the accumulator before a run, usually with all ones for the CRC modes, and reads the result after it.

Top module: `stream_sniffer`

## Requirements
- R1: While `rst` is high the accumulator is cleared to 0 and the control settings are cleared, so the block comes out of reset disabled and `result` reads 0.
- R2: A beat updates the accumulator only when the block is enabled, `beat_valid` and `beat_sniff_en` are both 1 and `beat_chan` equals the configured channel. Any other beat leaves `result` unchanged.
- R3: A `seed_wr` pulse loads `seed_data` into the accumulator at the next clock edge. It takes priority over a qualifying beat in the same cycle, and that beat is then dropped.
- R4: Mode 4'h0 is a CRC-32 with polynomial 0x04C11DB7. The accumulator shifts left, and the fed beat bits enter from the highest fed bit down to bit 0. No reflection and no final XOR are applied.
- R5: Mode 4'h1 is the CRC of R4, fed with the beat's fed bits in reversed order, so bit 0 of the fed field enters first.
- R6: Modes 4'h2 and 4'h3 run a CRC-16 with polynomial 0x1021 in accumulator bits 15:0. Mode 4'h2 feeds bits in plain order and mode 4'h3 in reversed order, as in R4 and R5. Each update clears bits 31:16.
- R7: Mode 4'hE XORs the parity of the fed bits into accumulator bit 0 and leaves bits 31:1 unchanged.
- R8: Mode 4'hF adds the fed bits, zero-extended, to the accumulator modulo 2^32.
- R9: `beat_size` 0 feeds bits 7:0, size 1 feeds bits 15:0, and sizes 2 and 3 feed all 32 bits. The upper lanes of narrow beats are ignored.
- R10: With input swap set, the bytes of the fed field are reversed before the bit order of R5 or R6 is applied. A byte beat passes through the swap unchanged.
- R11: The `result` output is the accumulator. If output reverse is set it is bit-reversed first, and if output invert is set it is then inverted. Neither option changes the accumulator.
- R12: Any mode value not listed in R4 to R8 leaves the accumulator unchanged on a qualifying beat.
- R13: A `ctrl_wr` pulse replaces the whole configuration at once. Writing all zeros disables the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_wr | input | 1 | Load all control fields below |
| ctrl_en | input | 1 | Enable value to load |
| ctrl_chan | input | CHAN_W | Watched channel to load |
| ctrl_mode | input | 4 | Algorithm mode to load |
| ctrl_in_swap | input | 1 | Input byte swap to load |
| ctrl_out_inv | input | 1 | Output invert to load |
| ctrl_out_rev | input | 1 | Output bit-reverse to load |
| seed_wr | input | 1 | Load the accumulator with `seed_data` |
| seed_data | input | 32 | Seed value |
| beat_valid | input | 1 | A DMA beat is present this cycle |
| beat_data | input | 32 | Beat data, low lanes used for narrow sizes |
| beat_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| beat_chan | input | CHAN_W | Channel that issued the beat |
| beat_sniff_en | input | 1 | That channel permits sniffing |
| result | output | 32 | Accumulator after the output options |

## Verification
Every mode is swept across all three beat sizes with input swap off and on. Each run starts from the seed a user would choose, and every step is compared with a bit-serial model. The beat sequence starts with all-zero and all-one words and then continues with pseudo-random words with dirty upper lanes. All-zero against all-one beats separates the polynomial and the shift direction. The dirty upper lanes show whether narrow beats are masked. The swap sweep separates byte reordering from bit reversal. Separate beats aim at each gating term on its own, the seed-versus-beat collision and the four output-option combinations. After each output combination the accumulator is read back plain to show that it was not disturbed.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    localparam int ACC_W = 32;
    localparam logic [31:0] POLY32 = 32'h04C1_1DB7;
    localparam logic [15:0] POLY16 = 16'h1021;

    typedef enum logic [3:0] {
        MODE_CRC32     = 4'h0,
        MODE_CRC32_REV = 4'h1,
        MODE_CRC16     = 4'h2,
        MODE_CRC16_REV = 4'h3,
        MODE_PARITY    = 4'hE,
        MODE_SUM       = 4'hF
    } sniff_mode_e;

    typedef struct packed {
        logic       en;
        logic [3:0] mode;
        logic       in_swap;
        logic       out_inv;
        logic       out_rev;
    } sniff_ctrl_t;

    typedef struct packed {
        logic [ACC_W-1:0] bits;
        logic [5:0]       nbits;
    } prep_beat_t;

    function automatic logic [ACC_W-1:0] rev32(input logic [ACC_W-1:0] v);
        logic [ACC_W-1:0] r;
        for (int i = 0; i < ACC_W; i++) r[i] = v[ACC_W-1-i];
        return r;
    endfunction

    function automatic logic [5:0] size_bits(input logic [1:0] sz);
        case (sz)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [ACC_W-1:0] low_mask(input logic [5:0] nb);
        if (nb >= 6'd32) return '1;
        return (32'h1 << nb) - 32'h1;
    endfunction

    function automatic logic [ACC_W-1:0] swap_lanes(input logic [ACC_W-1:0] v,
                                                    input logic [1:0] sz);
        case (sz)
            2'd0:    return v;
            2'd1:    return {16'h0, v[7:0], v[15:8]};
            default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
        endcase
    endfunction

    function automatic logic [ACC_W-1:0] crc32_feed(input logic [ACC_W-1:0] acc,
                                                    input logic [ACC_W-1:0] d,
                                                    input logic [5:0] nb);
        logic [ACC_W-1:0] a;
        logic fb;
        a = acc;
        for (int k = ACC_W - 1; k >= 0; k--) begin
            if (k < int'(nb)) begin
                fb = a[31] ^ d[k];
                a  = {a[30:0], 1'b0} ^ (fb ? POLY32 : 32'h0);
            end
        end
        return a;
    endfunction

    function automatic logic [15:0] crc16_feed(input logic [15:0] acc,
                                               input logic [ACC_W-1:0] d,
                                               input logic [5:0] nb);
        logic [15:0] a;
        logic fb;
        a = acc;
        for (int k = ACC_W - 1; k >= 0; k--) begin
            if (k < int'(nb)) begin
                fb = a[15] ^ d[k];
                a  = {a[14:0], 1'b0} ^ (fb ? POLY16 : 16'h0);
            end
        end
        return a;
    endfunction

endpackage

// File: rtl/sniff_ctrl_reg.sv
module sniff_ctrl_reg
    import sniff_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  sniff_ctrl_t       wr_ctrl,
    input  logic [CHAN_W-1:0] wr_chan,
    output sniff_ctrl_t       ctrl_q,
    output logic [CHAN_W-1:0] chan_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            chan_q <= '0;
        end else if (wr) begin
            ctrl_q <= wr_ctrl;
            chan_q <= wr_chan;
        end
    end

endmodule

// File: rtl/sniff_prep.sv
module sniff_prep
    import sniff_pkg::*;
(
    input  logic [ACC_W-1:0] data,
    input  logic [1:0]       size,
    input  logic             in_swap,
    input  logic [3:0]       mode,
    output prep_beat_t       beat
);

    logic [5:0]       nb;
    logic [ACC_W-1:0] masked;
    logic [ACC_W-1:0] swapped;
    logic             bit_rev;

    always_comb begin
        nb      = size_bits(size);
        masked  = data & low_mask(nb);
        swapped = in_swap ? swap_lanes(masked, size) : masked;
        bit_rev = (mode == MODE_CRC32_REV) || (mode == MODE_CRC16_REV);
        beat.nbits = nb;
        beat.bits  = bit_rev ? (rev32(swapped) >> (6'd32 - nb)) : swapped;
    end

endmodule

// File: rtl/sniff_engine.sv
module sniff_engine
    import sniff_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_wr,
    input  logic [ACC_W-1:0] seed_data,
    input  logic             hit,
    input  logic [3:0]       mode,
    input  prep_beat_t       beat,
    output logic [ACC_W-1:0] acc_q
);

    logic [ACC_W-1:0] acc_next;

    always_comb begin
        acc_next = acc_q;
        case (mode)
            MODE_CRC32, MODE_CRC32_REV:
                acc_next = crc32_feed(acc_q, beat.bits, beat.nbits);
            MODE_CRC16, MODE_CRC16_REV:
                acc_next = {16'h0, crc16_feed(acc_q[15:0], beat.bits, beat.nbits)};
            MODE_PARITY:
                acc_next = {acc_q[ACC_W-1:1], acc_q[0] ^ (^beat.bits)};
            MODE_SUM:
                acc_next = acc_q + beat.bits;
            default:
                acc_next = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (seed_wr) acc_q <= seed_data;
        else if (hit)     acc_q <= acc_next;
    end

endmodule

// File: rtl/sniff_out.sv
module sniff_out
    import sniff_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic             out_rev,
    input  logic             out_inv,
    output logic [ACC_W-1:0] value
);

    logic [ACC_W-1:0] ordered;

    always_comb begin
        ordered = out_rev ? rev32(acc) : acc;
        value   = out_inv ? ~ordered : ordered;
    end

endmodule

// File: rtl/stream_sniffer.sv
module stream_sniffer
    import sniff_pkg::*;
#(
    parameter int NUM_CHAN = 12,
    localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic [CHAN_W-1:0] ctrl_chan,
    input  logic [3:0]        ctrl_mode,
    input  logic              ctrl_in_swap,
    input  logic              ctrl_out_inv,
    input  logic              ctrl_out_rev,
    input  logic              seed_wr,
    input  logic [31:0]       seed_data,
    input  logic              beat_valid,
    input  logic [31:0]       beat_data,
    input  logic [1:0]        beat_size,
    input  logic [CHAN_W-1:0] beat_chan,
    input  logic              beat_sniff_en,
    output logic [31:0]       result
);

    sniff_ctrl_t       wr_ctrl;
    sniff_ctrl_t       ctrl_q;
    logic [CHAN_W-1:0] chan_q;
    prep_beat_t        beat;
    logic              hit;
    logic [ACC_W-1:0]  acc_q;

    always_comb begin
        wr_ctrl.en      = ctrl_en;
        wr_ctrl.mode    = ctrl_mode;
        wr_ctrl.in_swap = ctrl_in_swap;
        wr_ctrl.out_inv = ctrl_out_inv;
        wr_ctrl.out_rev = ctrl_out_rev;
    end

    sniff_ctrl_reg #(.CHAN_W(CHAN_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wr_ctrl (wr_ctrl),
        .wr_chan (ctrl_chan),
        .ctrl_q  (ctrl_q),
        .chan_q  (chan_q)
    );

    assign hit = ctrl_q.en && beat_valid && beat_sniff_en && (beat_chan == chan_q);

    sniff_prep u_prep (
        .data    (beat_data),
        .size    (beat_size),
        .in_swap (ctrl_q.in_swap),
        .mode    (ctrl_q.mode),
        .beat    (beat)
    );

    sniff_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .seed_wr   (seed_wr),
        .seed_data (seed_data),
        .hit       (hit),
        .mode      (ctrl_q.mode),
        .beat      (beat),
        .acc_q     (acc_q)
    );

    sniff_out u_out (
        .acc     (acc_q),
        .out_rev (ctrl_q.out_rev),
        .out_inv (ctrl_q.out_inv),
        .value   (result)
    );

endmodule

// File: rtl/sniff_checker.sv
module sniff_checker
    import sniff_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        seed_wr,
    input logic [31:0] seed_data,
    input logic        beat_valid,
    input logic        beat_sniff_en,
    input logic        hit,
    input sniff_ctrl_t ctrl_q,
    input logic [31:0] acc_q,
    input logic [31:0] result
);

    logic known_mode;
    assign known_mode = (ctrl_q.mode inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hE, 4'hF});

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (acc_q == 32'h0 && !ctrl_q.en)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((!beat_valid || !beat_sniff_en) && !seed_wr) |=> $stable(acc_q)); // R2

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        seed_wr |=> (acc_q == $past(seed_data))); // R3

    AST_CRC16_UPPER: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_wr && (ctrl_q.mode == 4'h2 || ctrl_q.mode == 4'h3))
        |=> (acc_q[31:16] == 16'h0)); // R6

    AST_PARITY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_wr && ctrl_q.mode == 4'hE)
        |=> (acc_q[31:1] == $past(acc_q[31:1]))); // R7

    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.out_inv && !ctrl_q.out_rev) |-> (result == acc_q)); // R11

    AST_UNKNOWN_MODE: assert property (@(posedge clk) disable iff (rst)
        (hit && !seed_wr && !known_mode) |=> $stable(acc_q)); // R12

endmodule

bind stream_sniffer sniff_checker u_sniff_chk (
    .clk           (clk),
    .rst           (rst),
    .seed_wr       (seed_wr),
    .seed_data     (seed_data),
    .beat_valid    (beat_valid),
    .beat_sniff_en (beat_sniff_en),
    .hit           (hit),
    .ctrl_q        (ctrl_q),
    .acc_q         (acc_q),
    .result        (result)
);

// File: tb/stream_sniffer_bench.sv
`timescale 1ns/1ps
module stream_sniffer_bench;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctrl_wr = 0, ctrl_en = 0, ctrl_in_swap = 0, ctrl_out_inv = 0, ctrl_out_rev = 0;
    logic [CW-1:0] ctrl_chan = '0;
    logic [3:0]    ctrl_mode = '0;
    logic          seed_wr = 0;
    logic [31:0]   seed_data = '0;
    logic          beat_valid = 0, beat_sniff_en = 0;
    logic [31:0]   beat_data = '0;
    logic [1:0]    beat_size = '0;
    logic [CW-1:0] beat_chan = '0;
    logic [31:0]   result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model;
    logic [31:0] lfsr = 32'hC0DE_1234;

    always #2 clk = ~clk;

    stream_sniffer u_stream_sniffer (
        .clk, .rst, .ctrl_wr, .ctrl_en, .ctrl_chan, .ctrl_mode, .ctrl_in_swap,
        .ctrl_out_inv, .ctrl_out_rev, .seed_wr, .seed_data, .beat_valid,
        .beat_data, .beat_size, .beat_chan, .beat_sniff_en, .result
    );

    function automatic logic [31:0] m_step(logic [31:0] a, logic [3:0] md, bit sw,
                                           int sz, logic [31:0] d);
        int w;
        logic [31:0] x, y, z;
        logic top;
        logic [15:0] h;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        x = (w == 32) ? d : (d & ((32'h1 << w) - 1));
        y = x;
        if (sw) begin
            y = '0;
            for (int b = 0; b < w / 8; b++) y[8*b +: 8] = x[8*(w/8-1-b) +: 8];
        end
        z = y;
        if (md == 4'h1 || md == 4'h3) begin
            z = '0;
            for (int i = 0; i < w; i++) z[i] = y[w-1-i];
        end
        case (md)
            4'h0, 4'h1: begin
                for (int i = w - 1; i >= 0; i--) begin
                    top = a[31] ^ z[i];
                    a = a << 1;
                    if (top) a = a ^ 32'h04C11DB7;
                end
            end
            4'h2, 4'h3: begin
                h = a[15:0];
                for (int i = w - 1; i >= 0; i--) begin
                    top = h[15] ^ z[i];
                    h = h << 1;
                    if (top) h = h ^ 16'h1021;
                end
                a = {16'h0, h};
            end
            4'hE: a[0] = a[0] ^ (^z);
            4'hF: a = a + z;
            default: ;
        endcase
        return a;
    endfunction

    function automatic logic [31:0] m_read(logic [31:0] a, bit inv, bit rv);
        logic [31:0] r;
        r = a;
        if (rv) for (int i = 0; i < 32; i++) r[i] = a[31-i];
        return inv ? ~r : r;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic cfg(bit en, int ch, logic [3:0] md, bit sw, bit inv, bit rv);
        ctrl_wr = 1; ctrl_en = en; ctrl_chan = CW'(ch); ctrl_mode = md;
        ctrl_in_swap = sw; ctrl_out_inv = inv; ctrl_out_rev = rv;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic seed(logic [31:0] v);
        seed_wr = 1; seed_data = v;
        @(negedge clk);
        seed_wr = 0;
    endtask

    task automatic beat(bit v, logic [31:0] d, int sz, int ch, bit sn);
        beat_valid = v; beat_data = d; beat_size = 2'(sz);
        beat_chan = CW'(ch); beat_sniff_en = sn;
        @(negedge clk);
        beat_valid = 0;
    endtask

    function automatic logic [31:0] next_rand(logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] modes[6];
        logic [31:0] d;
        logic [31:0] s;
        modes = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hE, 4'hF};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset result", result, 32'h0);
        beat(1, 32'h1234_5678, 2, 0, 1);
        chk("R1 disabled after reset", result, 32'h0);

        // Main sweep: R4 R5 R6 R7 R8 R9 R10
        for (int mi = 0; mi < 6; mi++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int sw = 0; sw < 2; sw++) begin
                    cfg(1, 5, modes[mi], sw[0], 0, 0);
                    s = (modes[mi] <= 4'h1) ? 32'hFFFF_FFFF :
                        (modes[mi] <= 4'h3) ? 32'h0000_FFFF : 32'h0;
                    seed(s);
                    model = s;
                    for (int k = 0; k < 8; k++) begin
                        if (k == 0) d = 32'h0;
                        else if (k == 1) d = 32'hFFFF_FFFF;
                        else begin lfsr = next_rand(lfsr); d = lfsr; end
                        beat(1, d, sz, 5, 1);
                        model = m_step(model, modes[mi], sw[0], sz, d);
                        case (modes[mi])
                            4'h0: chk("R4 crc32 R9 R10", result, model);
                            4'h1: chk("R5 crc32 reversed R9 R10", result, model);
                            4'h2, 4'h3: chk("R6 crc16 R9 R10", result, model);
                            4'hE: chk("R7 parity R9 R10", result, model);
                            default: chk("R8 sum R9 R10", result, model);
                        endcase
                    end
                end
            end
        end

        // R9: size code 3 behaves as a word
        cfg(1, 5, 4'h0, 0, 0, 0);
        seed(32'hFFFF_FFFF);
        beat(1, 32'hA5C3_0F96, 3, 5, 1);
        chk("R9 size 3 as word", result, m_step(32'hFFFF_FFFF, 4'h0, 0, 2, 32'hA5C3_0F96));

        // R2 gating terms
        cfg(1, 5, 4'hF, 0, 0, 0);
        seed(32'h0000_0100);
        beat(1, 32'h11, 2, 6, 1);
        chk("R2 channel mismatch", result, 32'h100);
        beat(1, 32'h11, 2, 5, 0);
        chk("R2 sniff flag low", result, 32'h100);
        beat(0, 32'h11, 2, 5, 1);
        chk("R2 beat not valid", result, 32'h100);
        cfg(0, 5, 4'hF, 0, 0, 0);
        beat(1, 32'h11, 2, 5, 1);
        chk("R2 disabled", result, 32'h100);
        cfg(0, 0, 4'h0, 0, 0, 0);
        beat(1, 32'h11, 2, 0, 1);
        chk("R13 all-zero control disables", result, 32'h100);
        cfg(1, 11, 4'hF, 0, 0, 0);
        beat(1, 32'h11, 2, 11, 1);
        chk("R13 new channel takes effect", result, 32'h111);

        // R3 seed beats a same-cycle beat
        seed_wr = 1; seed_data = 32'hDEAD_0000;
        beat(1, 32'h5, 2, 11, 1);
        seed_wr = 0;
        chk("R3 seed wins over beat", result, 32'hDEAD_0000);
        beat(1, 32'h5, 2, 11, 1);
        chk("R3 accumulate after seed", result, 32'hDEAD_0005);

        // R12 unknown mode
        cfg(1, 11, 4'h5, 0, 0, 0);
        beat(1, 32'h7777_7777, 2, 11, 1);
        chk("R12 unknown mode holds", result, 32'hDEAD_0005);

        // R11 output options
        for (int o = 0; o < 4; o++) begin
            cfg(1, 11, 4'hF, 0, o[0], o[1]);
            chk("R11 output option", result, m_read(32'hDEAD_0005, o[0], o[1]));
            cfg(1, 11, 4'hF, 0, 0, 0);
            chk("R11 accumulator undisturbed", result, 32'hDEAD_0005);
        end
        cfg(1, 11, 4'hF, 0, 1, 1);
        beat(1, 32'h10, 2, 11, 1);
        chk("R11 running value unaffected", result, m_read(32'hDEAD_0015, 1, 1));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule